// File: doc/BRIEF.md
# Low-rate raster timing generator

This block produces the horizontal and vertical timing of a reduced-resolution analog-monitor raster. It runs from one slow pixel clock, and a line lasts 264 clocks instead of the usual several hundred. A horizontal counter walks each line. A vertical counter takes one step each time the horizontal counter wraps. Each counter moves through four phases: visible, front porch, sync pulse and back porch. The end of every phase is found by a partial decode. That decode tests only the bits that are set in the count one clock before the boundary. Because no earlier count in the phase has all of those bits set, the test fires first at the right place.

The outputs are an active-low horizontal sync, an active-low vertical sync, a visible-area flag, and the current column and row counts, which can address a pixel store. All of these are plain control outputs, with no handshake. The block has no data input and applies no back-pressure. Every threshold is a parameter. The defaults are 200 visible units, sync from 210 up to 242, and a period of 264, on both axes.

Top module: `vga_lite_timing`

## Requirements
- R1: `px_x` counts up by one per clock from 0 to 263, and goes from 263 back to 0.
- R2: `px_y` holds its value except on the clock where `px_x` goes from 263 to 0. On that clock it steps by one, and after 263 it returns to 0. A full frame is 264 × 264 clocks.
- R3: `hsync_n` is 0 exactly while `px_x` lies in 210..241, which is 32 clocks per line. It changes on the same clock edge as `px_x`.
- R4: `vsync_n` is 0 exactly while `px_y` lies in 210..241, and is 1 on every other row.
- R5: `video_on` is 1 exactly when `px_x` < 200 and `px_y` < 200.
- R6: While `rst` is sampled high at a clock edge, both counts go to 0, both sync outputs go to 1 and `video_on` goes to 1. After `rst` falls, counting restarts from (0,0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| hsync_n | output | 1 | Horizontal sync, active low, registered |
| vsync_n | output | 1 | Vertical sync, active low, registered |
| video_on | output | 1 | High inside the visible area |
| px_x | output | HW (9) | Current column count |
| px_y | output | VW (9) | Current row count |

## Verification
A phase register that falls out of step with its counter shows up as a sync pulse or visible flag that is shifted or stretched against `px_x` or `px_y`. The per-clock reference comparison catches this on the first misplaced clock, within one line for the horizontal axis and within one frame for the vertical. A decode mask that is wrong by one bit moves a boundary or stops the wrap. A runaway count is visible at once, and a vertical fault is visible within 264 clocks of the first wrap.

// File: rtl/vga_lite_pkg.sv
package vga_lite_pkg;

  // Phases of one raster axis, in the order they occur
  typedef enum logic [1:0] {
    PH_VIS   = 2'd0,
    PH_FRONT = 2'd1,
    PH_PULSE = 2'd2,
    PH_BACK  = 2'd3
  } phase_t;

  localparam int DEC_W = 16;

  // Partial decode: true when every bit set in pat is also set in val.
  // The first count reaching this is pat itself.
  function automatic logic bits_hit(input logic [DEC_W-1:0] val,
                                    input logic [DEC_W-1:0] pat);
    return &(val | ~pat);
  endfunction

endpackage

// File: rtl/raster_axis.sv
module raster_axis
  import vga_lite_pkg::*;
#(
  parameter int TOTAL    = 264,
  parameter int ACTIVE   = 200,
  parameter int SYNC_ON  = 210,
  parameter int SYNC_OFF = 242,
  parameter int W        = $clog2(TOTAL)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         step,
  output logic [W-1:0] count,
  output logic         visible,
  output logic         sync_n,
  output logic         last
);

  // Each pattern is the count one clock before its boundary
  localparam logic [DEC_W-1:0] PAT_LAST  = DEC_W'(TOTAL - 1);
  localparam logic [DEC_W-1:0] PAT_FRONT = DEC_W'(ACTIVE - 1);
  localparam logic [DEC_W-1:0] PAT_PULSE = DEC_W'(SYNC_ON - 1);
  localparam logic [DEC_W-1:0] PAT_BACK  = DEC_W'(SYNC_OFF - 1);

  phase_t       phase, phase_nxt;
  logic [W-1:0] count_nxt;
  logic         hit_last, hit_front, hit_pulse, hit_back;

  always_comb begin
    hit_last  = bits_hit(DEC_W'(count), PAT_LAST);
    hit_front = bits_hit(DEC_W'(count), PAT_FRONT);
    hit_pulse = bits_hit(DEC_W'(count), PAT_PULSE);
    hit_back  = bits_hit(DEC_W'(count), PAT_BACK);
  end

  assign last = step & hit_last;

  // Each move is tested only from its own predecessor phase, so a later
  // count that happens to match a pattern again does no harm
  always_comb begin
    count_nxt = count;
    phase_nxt = phase;
    if (step) begin
      if (hit_last) begin
        count_nxt = '0;
        phase_nxt = PH_VIS;
      end else begin
        count_nxt = count + 1'b1;
        unique case (phase)
          PH_VIS:   if (hit_front) phase_nxt = PH_FRONT;
          PH_FRONT: if (hit_pulse) phase_nxt = PH_PULSE;
          PH_PULSE: if (hit_back)  phase_nxt = PH_BACK;
          default:  phase_nxt = PH_BACK;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      phase  <= PH_VIS;
      sync_n <= 1'b1;
    end else begin
      count  <= count_nxt;
      phase  <= phase_nxt;
      sync_n <= (phase_nxt != PH_PULSE);
    end
  end

  assign visible = (phase == PH_VIS);

  // R1 R2
  count_range_chk: assert property (@(posedge clk) disable iff (rst)
    32'(count) < TOTAL);

  // R1 R2
  count_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (step && 32'(count) == TOTAL - 1) |=> (count == '0));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(count));

  // R3 R4
  sync_window_chk: assert property (@(posedge clk) disable iff (rst)
    sync_n == !(32'(count) >= SYNC_ON && 32'(count) < SYNC_OFF));

  // R5
  visible_window_chk: assert property (@(posedge clk) disable iff (rst)
    visible == (32'(count) < ACTIVE));

  // R6
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (count == '0 && sync_n && visible));

endmodule

// File: rtl/vga_lite_timing.sv
module vga_lite_timing #(
  parameter int H_TOTAL    = 264,
  parameter int H_ACTIVE   = 200,
  parameter int H_SYNC_ON  = 210,
  parameter int H_SYNC_OFF = 242,
  parameter int V_TOTAL    = 264,
  parameter int V_ACTIVE   = 200,
  parameter int V_SYNC_ON  = 210,
  parameter int V_SYNC_OFF = 242,
  parameter int HW         = $clog2(H_TOTAL),
  parameter int VW         = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hsync_n,
  output logic          vsync_n,
  output logic          video_on,
  output logic [HW-1:0] px_x,
  output logic [VW-1:0] px_y
);

  logic h_vis, v_vis, h_last, v_last;

  raster_axis #(
    .TOTAL(H_TOTAL), .ACTIVE(H_ACTIVE),
    .SYNC_ON(H_SYNC_ON), .SYNC_OFF(H_SYNC_OFF), .W(HW)
  ) u_hor (
    .clk(clk), .rst(rst), .step(1'b1),
    .count(px_x), .visible(h_vis), .sync_n(hsync_n), .last(h_last)
  );

  raster_axis #(
    .TOTAL(V_TOTAL), .ACTIVE(V_ACTIVE),
    .SYNC_ON(V_SYNC_ON), .SYNC_OFF(V_SYNC_OFF), .W(VW)
  ) u_ver (
    .clk(clk), .rst(rst), .step(h_last),
    .count(px_y), .visible(v_vis), .sync_n(vsync_n), .last(v_last)
  );

  assign video_on = h_vis & v_vis;

  // R2
  frame_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    v_last |=> (px_x == '0 && px_y == '0));

  // R2
  row_step_chk: assert property (@(posedge clk) disable iff (rst)
    (h_last && !v_last) |=> (px_y == $past(px_y) + 1'b1));

endmodule

// File: tb/sim_vga_lite_timing.sv
module sim_vga_lite_timing;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       hsync_n, vsync_n, video_on;
  logic [8:0] px_x, px_y;

  int checks = 0;
  int errors = 0;
  int hx = 0;
  int vy = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vga_lite_timing u0 (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .video_on(video_on), .px_x(px_x), .px_y(px_y)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors <= 25)
        $display("FAIL %s at x=%0d y=%0d: got %0d want %0d", req, hx, vy, act, exp);
    end
  endtask

  // Advance the reference by one edge, then compare mid-cycle
  task automatic step();
    @(posedge clk);
    if (rst) begin
      hx = 0; vy = 0;
    end else if (hx == 263) begin
      hx = 0;
      vy = (vy == 263) ? 0 : vy + 1;
    end else begin
      hx = hx + 1;
    end
    @(negedge clk);
    chk("R1 px_x", int'(px_x), hx);
    chk("R2 px_y", int'(px_y), vy);
    chk("R3 hsync_n", int'(hsync_n), (hx >= 210 && hx < 242) ? 0 : 1);
    chk("R4 vsync_n", int'(vsync_n), (vy >= 210 && vy < 242) ? 0 : 1);
    chk("R5 video_on", int'(video_on), (hx < 200 && vy < 200) ? 1 : 0);
  endtask

  initial begin
    rst = 1'b1;
    for (int i = 0; i < 3; i++) step();
    // R6: held in reset
    chk("R6 reset x", int'(px_x), 0);
    chk("R6 reset hsync", int'(hsync_n), 1);
    @(negedge clk) rst = 1'b0;
    // a whole frame plus part of the next, covering every boundary
    for (int i = 0; i < 264 * 264 + 800; i++) step();
    chk("R2 second frame row", int'(px_y), 3);
    // R6: reset in the middle of a line
    for (int i = 0; i < 215; i++) step();
    @(negedge clk) rst = 1'b1;
    step();
    step();
    chk("R6 mid reset x", int'(px_x), 0);
    chk("R6 mid reset y", int'(px_y), 0);
    @(negedge clk) rst = 1'b0;
    for (int i = 0; i < 2000; i++) step();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(10 * 190000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not finish, got hang want completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule